// File: doc/BRIEF.md
# Serial Configuration Port for a Fractional-N Synthesizer

This block is the write-only configuration front end of a fractional-N synthesizer and modulator. Three pins carry a serial data bit, a serial clock and a latch strobe. While the latch strobe is low, each rising serial clock shifts one bit into a 24-bit word, most significant bit first. The rising edge of the latch strobe commits that word to the internal register whose number is held in its three lowest bits.

The block keeps only the register fields that drive the synthesizer. These are the charge pump current step, the charge pump reference source, the monitor output multiplexer select and the PLL power control. The block turns them into plain control outputs. All three pins are sampled in the system clock domain through synchronizers. Each pin level must therefore be held for at least SYNC_STAGES+2 system clocks. The block has no data stream with flow control: the serial port cannot apply back-pressure, so a word is accepted whenever the host strobes it. Writes to register numbers that carry no decoded field are accepted and have no effect on any output.

Top module: `pll_cfg_serial_if`

## Requirements
- R1: While ser_le is low, each rising edge of ser_clk shifts the level of ser_dat into the word, so the first bit sent ends up as bit 23 and the last bit sent as bit 0.
- R2: A rising edge of ser_le commits the held word to the register numbered by word bits 2:0. The outputs show the new value by the third rising system clock after ser_le rises. A word with fields laid out for register 4 but a different number in bits 2:0 does not change the register 4 outputs.
- R3: When more than 24 bits are shifted before a commit, only the last 24 bits sent are used.
- R4: Rising edges of ser_clk while ser_le is high shift nothing. A later commit that has no new bits shifted in writes the earlier word again.
- R5: Register 4 bits 11:10 drive cp_cur_code, encoded 00=250 uA, 01=500 uA, 10=750 uA and 11=1000 uA.
- R6: Register 4 bit 18 drives cp_ext_ref: 0 selects the internal reference and 1 selects the external resistor path.
- R7: Register 4 bits 23:21 drive mux_sel. Code 000 is digital lock detect, 001 is the temperature-proportional voltage, and the higher codes select scaled reference outputs.
- R8: pll_en is 0 when register 6 bits 20:17 are all zero, and 1 otherwise.
- R9: The outputs change only as a result of a commit. They stay unchanged while bits are being shifted. A commit to any register other than 4 or 6 leaves every output unchanged.
- R10: On reset, cp_cur_code is 01, cp_ext_ref is 0, mux_sel is 000 and pll_en is 1 (register 6 bits 20:17 reset to 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_le | input | 1 | Latch strobe: low while shifting, rising edge commits |
| cp_cur_code | output | 2 | Charge pump current step |
| cp_ext_ref | output | 1 | Charge pump reference source select |
| mux_sel | output | 3 | Monitor output multiplexer select |
| pll_en | output | 1 | Internal PLL power enable |

## Verification
Register 4 words are sent with field values that differ from each other in every field, so a wrong bit order, a swapped field or a missed commit each give a different output pattern. Register 6 words switch pll_en off with an all-zero field and back on with a single set bit. Words for other register numbers, including one with register 4 field bits but a different number, show that the address decode alone picks the target. An over-long word and a burst of serial clocks sent with the latch high are chosen so that keeping the wrong 24 bits, or shifting while latched, would land on register 4 with a visibly different mux_sel. A run of pseudo-random words to registers 3, 4 and 6 then exercises mixed traffic.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int CFG_WORD_W = 24;
  localparam int CFG_ADDR_W = 3;
  localparam int CP_W  = 2;
  localparam int MUX_W = 3;
  localparam int PWR_W = 4;
  localparam int NUM_FIELDS = 4;
  localparam int F_CP  = 0;
  localparam int F_EXT = 1;
  localparam int F_MUX = 2;
  localparam int F_PWR = 3;

  // register number that owns each field
  function automatic int fld_reg(input int i);
    case (i)
      F_PWR:   return 6;
      default: return 4;
    endcase
  endfunction

  // bit position of each field inside the 24-bit word
  function automatic int fld_lsb(input int i);
    case (i)
      F_CP:    return 10;
      F_EXT:   return 18;
      F_MUX:   return 21;
      default: return 17;
    endcase
  endfunction

  function automatic int fld_w(input int i);
    case (i)
      F_CP:    return CP_W;
      F_EXT:   return 1;
      F_MUX:   return MUX_W;
      default: return PWR_W;
    endcase
  endfunction

  // reset value: 500 uA step, PLL powered
  function automatic int fld_rst(input int i);
    case (i)
      F_CP:    return 1;
      F_PWR:   return 8;
      default: return 0;
    endcase
  endfunction

  // offset of each field inside the packed field bus
  function automatic int fld_ofs(input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += fld_w(j);
    return s;
  endfunction

  localparam int FLD_BUS_W = fld_ofs(NUM_FIELDS);
endpackage

// File: rtl/pll_cfg_pin_sync.sv
module pll_cfg_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/pll_cfg_rise.sv
module pll_cfg_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pll_cfg_shifter.sv
module pll_cfg_shifter
  import pll_cfg_pkg::*;
#(
  parameter int WORD_W = CFG_WORD_W,
  parameter int ADDR_W = CFG_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [FLD_BUS_W-1:0] raw_o
);
  logic [WORD_W-1:0] word_q;

  // MSB first: newest bit enters at bit 0, oldest falls off the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign addr_o = word_q[ADDR_W-1:0];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_view
    localparam int LSB = fld_lsb(f);
    localparam int FW  = fld_w(f);
    localparam int OFS = fld_ofs(f);
    assign raw_o[OFS +: FW] = word_q[LSB +: FW];
  end
endmodule

// File: rtl/pll_cfg_field_reg.sv
module pll_cfg_field_reg #(
  parameter int ADDR_W = 3,
  parameter int SEL    = 4,
  parameter int W      = 2,
  parameter int RST    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      fld_i,
  output logic [W-1:0]      q_o
);
  logic hit;
  assign hit = commit_i && (addr_i == ADDR_W'(SEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= W'(RST);
    else if (hit) q_o <= fld_i;
  end
endmodule

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
  import pll_cfg_pkg::*;
(
  input  logic [FLD_BUS_W-1:0] bus_i,
  output logic [CP_W-1:0]      cp_code_o,
  output logic                 ext_ref_o,
  output logic [MUX_W-1:0]     mux_sel_o,
  output logic                 pll_en_o
);
  localparam int O_CP  = fld_ofs(F_CP);
  localparam int O_EXT = fld_ofs(F_EXT);
  localparam int O_MUX = fld_ofs(F_MUX);
  localparam int O_PWR = fld_ofs(F_PWR);

  assign cp_code_o = bus_i[O_CP +: CP_W];
  assign ext_ref_o = bus_i[O_EXT];
  assign mux_sel_o = bus_i[O_MUX +: MUX_W];
  // any nonzero power field keeps the internal loop running
  assign pll_en_o  = |bus_i[O_PWR +: PWR_W];
endmodule

// File: rtl/pll_cfg_serial_if.sv
module pll_cfg_serial_if
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = CFG_WORD_W,
  parameter int ADDR_W      = CFG_ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_dat,
  input  logic             ser_clk,
  input  logic             ser_le,
  output logic [CP_W-1:0]  cp_cur_code,
  output logic             cp_ext_ref,
  output logic [MUX_W-1:0] mux_sel,
  output logic             pll_en
);
  localparam int NPINS = 3;

  logic [NPINS-1:0]     pin_lvl;
  logic [1:0]           edge_rise;
  logic                 shift_en;
  logic                 commit;
  logic [ADDR_W-1:0]    cur_addr;
  logic [FLD_BUS_W-1:0] raw_fld;
  logic [FLD_BUS_W-1:0] fld_bus;

  pll_cfg_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({ser_le, ser_clk, ser_dat}),
    .lvl_o (pin_lvl)
  );

  pll_cfg_rise #(.W(2)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pin_lvl[2:1]),
    .rise_o (edge_rise)
  );

  assign shift_en = edge_rise[0] & ~pin_lvl[2];
  assign commit   = edge_rise[1];

  pll_cfg_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_en),
    .bit_i   (pin_lvl[0]),
    .addr_o  (cur_addr),
    .raw_o   (raw_fld)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int FW  = fld_w(f);
    localparam int OFS = fld_ofs(f);
    pll_cfg_field_reg #(
      .ADDR_W (ADDR_W),
      .SEL    (fld_reg(f)),
      .W      (FW),
      .RST    (fld_rst(f))
    ) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .addr_i   (cur_addr),
      .fld_i    (raw_fld[OFS +: FW]),
      .q_o      (fld_bus[OFS +: FW])
    );
  end

  pll_cfg_decode u_dec (
    .bus_i     (fld_bus),
    .cp_code_o (cp_cur_code),
    .ext_ref_o (cp_ext_ref),
    .mux_sel_o (mux_sel),
    .pll_en_o  (pll_en)
  );
endmodule

// File: rtl/pll_cfg_serial_if_chk.sv
module pll_cfg_serial_if_chk
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 shift_en,
  input logic                 commit,
  input logic [ADDR_W-1:0]    addr,
  input logic [FLD_BUS_W-1:0] raw,
  input logic [CP_W-1:0]      cp_cur_code,
  input logic                 cp_ext_ref,
  input logic [MUX_W-1:0]     mux_sel,
  input logic                 pll_en
);
  localparam int O_CP  = fld_ofs(F_CP);
  localparam int O_EXT = fld_ofs(F_EXT);
  localparam int O_MUX = fld_ofs(F_MUX);
  localparam int O_PWR = fld_ofs(F_PWR);

  logic hit4, hit6;
  assign hit4 = commit && addr == ADDR_W'(4);
  assign hit6 = commit && addr == ADDR_W'(6);

  AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable({addr, raw})); // R4

  AST_CP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit4 |=> cp_cur_code == $past(raw[O_CP +: CP_W])); // R5

  AST_EXTREF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit4 |=> cp_ext_ref == $past(raw[O_EXT])); // R6

  AST_MUX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit4 |=> mux_sel == $past(raw[O_MUX +: MUX_W])); // R7

  AST_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hit6 && raw[O_PWR +: PWR_W] == '0 |=> !pll_en); // R8

  AST_PLL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hit6 && raw[O_PWR +: PWR_W] != '0 |=> pll_en); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({cp_cur_code, cp_ext_ref, mux_sel, pll_en})); // R9

  AST_OTHER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !hit4 && !hit6 |=> $stable({cp_cur_code, cp_ext_ref, mux_sel, pll_en})); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_VALUES: assert (cp_cur_code == 2'b01 && !cp_ext_ref && mux_sel == 3'b000 && pll_en); // R10
    end
  end
endmodule

bind pll_cfg_serial_if pll_cfg_serial_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shift_en    (shift_en),
  .commit      (commit),
  .addr        (cur_addr),
  .raw         (raw_fld),
  .cp_cur_code (cp_cur_code),
  .cp_ext_ref  (cp_ext_ref),
  .mux_sel     (mux_sel),
  .pll_en      (pll_en)
);

// File: tb/pll_cfg_serial_if_tb.sv
module pll_cfg_serial_if_tb;
  logic clk = 1'b0;
  logic rst_n, sdat, sclk, sle;
  logic [1:0] cp_cur_code;
  logic       cp_ext_ref;
  logic [2:0] mux_sel;
  logic       pll_en;
  logic [6:0] outs;

  always #10 clk = ~clk; // 50 MHz

  pll_cfg_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .ser_dat(sdat), .ser_clk(sclk), .ser_le(sle),
    .cp_cur_code(cp_cur_code), .cp_ext_ref(cp_ext_ref), .mux_sel(mux_sel), .pll_en(pll_en)
  );

  assign outs = {cp_cur_code, cp_ext_ref, mux_sel, pll_en};

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  event       ev_word;

  // reference model built from the requirements
  logic [23:0] sh_model = '0;
  logic [1:0]  m_cp  = 2'b01;
  logic        m_ext = 1'b0;
  logic [2:0]  m_mux = 3'b000;
  logic        m_pll = 1'b1;

  function automatic logic [6:0] model_outs();
    return {m_cp, m_ext, m_mux, m_pll};
  endfunction

  function automatic logic [23:0] mk4(logic [1:0] cp, logic ext, logic [2:0] mx);
    return {mx, 2'b00, ext, 6'b0, cp, 7'b0, 3'd4};
  endfunction

  function automatic logic [23:0] mk6(logic [3:0] pw);
    return {3'b000, pw, 14'b0, 3'd6};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {cp,ext,mux,pll}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic model_commit();
    if (sh_model[2:0] == 3'd4) begin
      m_cp  = sh_model[11:10];
      m_ext = sh_model[18];
      m_mux = sh_model[23:21];
    end else if (sh_model[2:0] == 3'd6) begin
      m_pll = |sh_model[20:17];
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    sdat = b;
    wait_clk(4);
    sclk = 1'b1;
    if (!sle) sh_model = {sh_model[22:0], b};
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic finish_commit(string req);
    sle = 1'b1;
    model_commit();
    exp_q.push_back(model_outs());
    tag_q.push_back(req);
    wait_clk(5); // settled by the third system edge
    -> ev_word;
    wait_clk(2);
  endtask

  task automatic send(logic [31:0] w, int n, string req);
    sle = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      put_bit(w[i]);
      if (i == n / 2) check("R9 mid-word hold", outs, model_outs());
    end
    finish_commit(req);
  endtask

  task automatic relatch(string req);
    sle = 1'b0;
    wait_clk(4);
    finish_commit(req);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(ev_word);
      check(tag_q.pop_front(), outs, exp_q.pop_front());
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] lf;
    sdat = 1'b0; sclk = 1'b0; sle = 1'b0; rst_n = 1'b1;
    #5 rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check("R10 reset values", outs, 7'b01_0_000_1);

    send({8'h00, mk4(2'b11, 1'b1, 3'b010)}, 24, "R1/R2/R5/R6/R7 reg4 write A");
    send({8'h00, mk4(2'b00, 1'b0, 3'b001)}, 24, "R5/R7 reg4 write B");
    send({8'h00, mk4(2'b10, 1'b1, 3'b100)}, 24, "R5/R6 reg4 write C");
    send({8'h00, mk6(4'b0000)}, 24, "R8 power field zero");
    send({8'h00, mk6(4'b0010)}, 24, "R8 power field nonzero");
    send({8'h00, 21'h1FFFFF, 3'd5}, 24, "R9 write to reg5");
    send({8'h00, 21'h1FFFFF, 3'd0}, 24, "R9 write to reg0");
    send({8'h00, mk4(2'b01, 1'b0, 3'b111) ^ 24'd7}, 24, "R2 reg4 layout at reg3");
    send({8'hFE, mk4(2'b01, 1'b0, 3'b110)}, 32, "R3 over-long word");

    send({8'h00, mk6(4'b1110)}, 24, "R8 power write before latched clocks");
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b0);
    relatch("R4 clocks with latch high");

    lf = 24'hACE1B5;
    for (int k = 0; k < 8; k++) begin
      lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
      lf[2:0] = (k % 3 == 0) ? 3'd4 : ((k % 3 == 1) ? 3'd6 : 3'd3);
      send({8'h00, lf}, 24, "R2/R5/R8 mixed traffic");
    end

    wait_clk(10);
    summary();
    $finish;
  end
endmodule